// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Cell

This block is one processing element of a weight-stationary matrix-multiply grid. It keeps one signed 8-bit weight. Activations enter on the west side and leave on the east side. Partial sums enter on the north side and leave on the south side. A single strobe, shared by every cell of a column, selects one of two roles for the cell.

While the strobe is high, the cell is being loaded. It takes its new weight from the partial-sum input and sends that weight south, so that the next cell down can capture it on the following cycle. Weights therefore travel down the column through the partial-sum chain, and no separate weight bus is needed. While the strobe is low, the cell computes. It passes the activation east and sends south the incoming partial sum plus its weight times the activation. After a load, the first value that enters the top of a column serves as the bias, and the values after it are running partial sums.

All three outputs are registered, so each has one cycle of latency. The 32-bit sum wraps in two's complement.

Top module: `wsa_cell`

## Requirements
- R1: An active-low reset, asserted at any time, clears the stored weight, `act_out` and `psum_out` to zero. After reset, a compute cycle therefore returns `psum_in` unchanged on `psum_out`.
- R2: When `load_en` is 1 at a rising edge, the stored weight becomes bits [7:0] of `psum_in`, read as a signed two's-complement value. Bits [31:8] are not used for the weight.
- R3: After a load edge, `psum_out` holds bits [7:0] of `psum_in` sign-extended to 32 bits.
- R4: After a load edge, `act_out` is zero, whatever `act_in` was.
- R5: When `load_en` is 0 at a rising edge, `psum_out` becomes `psum_in + weight * act_in`. Here `act_in` and the weight are signed 8-bit values and the sum is signed 32-bit. The weight used is the one stored before that edge.
- R6: When `load_en` is 0 at a rising edge, `act_out` becomes the value `act_in` had at that edge.
- R7: The stored weight does not change on a compute edge. It is used again in every later compute cycle until the next load.
- R8: The 32-bit accumulation wraps modulo 2^32 and does not saturate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Column load strobe: 1 = load weight, 0 = multiply-accumulate |
| act_in | input | 8 | Signed activation from the west neighbour |
| act_out | output | 8 | Registered activation to the east neighbour (zero after a load) |
| psum_in | input | 32 | Signed partial sum from the north, or the weight being loaded |
| psum_out | output | 32 | Registered partial sum, or the cascaded weight, to the south |

## Verification
The weight register cannot be seen directly. A wrong weight shows up as a wrong `psum_out` one cycle after the first compute edge that follows the faulty load or reset. A wrong value of zero looks identical to pass-through, so the checks use non-zero activations. A weight changed by a compute edge, or captured from the wrong bits, is caught by a second compute with the same activation, or by a load value whose upper bits are non-zero. A zeroing or sign-extension fault on the load path shows on `act_out` and `psum_out` on the very next cycle.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

    // Default operand and accumulator widths
    localparam int unsigned DEF_ACT_W  = 8;
    localparam int unsigned DEF_WGT_W  = 8;
    localparam int unsigned DEF_PSUM_W = 32;

    // Role chosen by the column strobe
    typedef enum logic {
        CELL_MAC  = 1'b0,
        CELL_LOAD = 1'b1
    } cell_mode_e;

endpackage

// File: rtl/wsa_mul.sv
// Signed operand product, full width, combinational
module wsa_mul #(
    parameter int unsigned A_W = 8,
    parameter int unsigned B_W = 8,
    localparam int unsigned P_W = A_W + B_W
) (
    input  logic signed [A_W-1:0] a,
    input  logic signed [B_W-1:0] b,
    output logic signed [P_W-1:0] p
);

    logic signed [P_W-1:0] a_ext;
    logic signed [P_W-1:0] b_ext;

    always_comb begin
        a_ext = P_W'(a);
        b_ext = P_W'(b);
        p     = a_ext * b_ext;
    end

endmodule

// File: rtl/wsa_add.sv
// Wrapping accumulator adder: sign-extends the product to the sum width
module wsa_add #(
    parameter int unsigned P_W   = 16,
    parameter int unsigned SUM_W = 32
) (
    input  logic signed [SUM_W-1:0] base,
    input  logic signed [P_W-1:0]   prod,
    output logic signed [SUM_W-1:0] sum
);

    logic signed [SUM_W-1:0] prod_ext;

    always_comb begin
        prod_ext = SUM_W'(prod);
        sum      = base + prod_ext;
    end

endmodule

// File: rtl/wsa_cell.sv
module wsa_cell
    import wsa_pkg::*;
#(
    parameter int unsigned ACT_W  = DEF_ACT_W,
    parameter int unsigned WGT_W  = DEF_WGT_W,
    parameter int unsigned PSUM_W = DEF_PSUM_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic signed [ACT_W-1:0]  act_in,
    output logic signed [ACT_W-1:0]  act_out,
    input  logic signed [PSUM_W-1:0] psum_in,
    output logic signed [PSUM_W-1:0] psum_out
);

    localparam int unsigned PROD_W = ACT_W + WGT_W;

    typedef struct packed {
        logic signed [WGT_W-1:0]  weight;
        logic signed [ACT_W-1:0]  act;
        logic signed [PSUM_W-1:0] psum;
    } cell_state_t;

    cell_state_t state_d;
    cell_state_t state_q;
    cell_mode_e  mode;

    logic signed [WGT_W-1:0]  weight_q;
    logic signed [WGT_W-1:0]  new_weight;
    logic signed [PROD_W-1:0] prod;
    logic signed [PSUM_W-1:0] mac_sum;

    assign weight_q   = state_q.weight;
    assign mode       = cell_mode_e'(load_en);
    assign new_weight = psum_in[WGT_W-1:0];

    wsa_mul #(
        .A_W (WGT_W),
        .B_W (ACT_W)
    ) u_mul (
        .a (weight_q),
        .b (act_in),
        .p (prod)
    );

    wsa_add #(
        .P_W   (PROD_W),
        .SUM_W (PSUM_W)
    ) u_add (
        .base (psum_in),
        .prod (prod),
        .sum  (mac_sum)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (mode)
            CELL_LOAD: begin
                state_d.weight = new_weight;
                state_d.act    = '0;
                state_d.psum   = PSUM_W'(new_weight);
            end
            default: begin
                state_d.weight = weight_q;
                state_d.act    = act_in;
                state_d.psum   = mac_sum;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign act_out  = state_q.act;
    assign psum_out = state_q.psum;

endmodule

// File: rtl/wsa_cell_chk.sv
module wsa_cell_chk #(
    parameter int unsigned ACT_W  = 8,
    parameter int unsigned WGT_W  = 8,
    parameter int unsigned PSUM_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     load_en,
    input logic signed [ACT_W-1:0]  act_in,
    input logic signed [ACT_W-1:0]  act_out,
    input logic signed [PSUM_W-1:0] psum_in,
    input logic signed [PSUM_W-1:0] psum_out,
    input logic signed [WGT_W-1:0]  weight_q
);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> weight_q == $past(psum_in[WGT_W-1:0]));

    // R3
    load_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> psum_out == PSUM_W'($signed($past(psum_in[WGT_W-1:0]))));

    // R4
    load_act_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> act_out == '0);

    // R6
    act_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> act_out == $past(act_in));

    // R7
    weight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(weight_q));

    // R5
    zero_weight_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && weight_q == '0) |=> psum_out == $past(psum_in));

endmodule

bind wsa_cell wsa_cell_chk #(
    .ACT_W  (ACT_W),
    .WGT_W  (WGT_W),
    .PSUM_W (PSUM_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .act_in   (act_in),
    .act_out  (act_out),
    .psum_in  (psum_in),
    .psum_out (psum_out),
    .weight_q (weight_q)
);

// File: tb/wsa_cell_tb.sv
`timescale 1ns / 1ps
module wsa_cell_tb;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               load_en = 1'b0;
    logic signed [7:0]  act_in = '0;
    logic signed [7:0]  act_out;
    logic signed [31:0] psum_in = '0;
    logic signed [31:0] psum_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wsa_cell u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .act_in   (act_in),
        .act_out  (act_out),
        .psum_in  (psum_in),
        .psum_out (psum_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, sample at the next one
    task automatic step(input logic ld, input logic signed [7:0] a, input logic signed [31:0] p);
        load_en = ld;
        act_in  = a;
        psum_in = p;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 act_out at reset", 32'(act_out), 32'h0);
        chk("R1 psum_out at reset", psum_out, 32'h0);
        step(1'b0, 8'sd5, 32'sd100);
        chk("R1 cleared weight passes psum", psum_out, 32'd100);
    endtask

    task automatic t_load_negative();
        step(1'b1, 8'sd77, 32'h1234_56FD);
        chk("R3 load cascades sign-extended weight", psum_out, 32'hFFFF_FFFD);
        chk("R4 act_out zero during load", 32'(act_out), 32'h0);
        step(1'b0, 8'sd10, 32'sd1000);
        chk("R2 R5 mac with -3*10", psum_out, 32'(970));
        chk("R6 act passes east", 32'(act_out), 32'(10));
        step(1'b0, -8'sd128, 32'sd0);
        chk("R5 mac with -3*-128", psum_out, 32'(384));
        chk("R6 negative act passes", 32'(act_out), 32'hFFFF_FF80);
    endtask

    task automatic t_weight_hold();
        step(1'b0, 8'sd1, 32'sd0);
        chk("R7 weight kept after computes", psum_out, 32'hFFFF_FFFD);
        step(1'b0, 8'sd2, -32'sd6);
        chk("R7 weight kept again", psum_out, 32'hFFFF_FFF4);
    endtask

    task automatic t_load_positive_extreme();
        step(1'b1, -8'sd1, 32'hFFFF_FF7F);
        chk("R3 positive weight zero-extended", psum_out, 32'h0000_007F);
        chk("R4 act_out zero on second load", 32'(act_out), 32'h0);
        step(1'b0, -8'sd128, -32'sd1000);
        chk("R5 127*-128 plus bias", psum_out, 32'(-17256));
    endtask

    task automatic t_wrap();
        step(1'b1, 8'sd0, 32'h0000_0080);
        chk("R3 weight -128 cascade", psum_out, 32'hFFFF_FF80);
        step(1'b0, -8'sd128, 32'h7FFF_FFFF);
        chk("R8 wrap past max positive", psum_out, 32'h8000_3FFF);
        step(1'b0, 8'sd127, 32'h8000_0000);
        chk("R8 wrap past max negative", psum_out, 32'h7FFF_C080);
    endtask

    task automatic t_async_reset();
        step(1'b0, 8'sd3, 32'sd50);
        #1 rst_n = 1'b0;
        #1;
        chk("R1 async reset clears act_out", 32'(act_out), 32'h0);
        chk("R1 async reset clears psum_out", psum_out, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 8'sd9, 32'sd7);
        chk("R1 weight cleared by reset", psum_out, 32'd7);
        chk("R6 act after reset", 32'(act_out), 32'd9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_load_negative();
        t_weight_hold();
        t_load_positive_extreme();
        t_wrap();
        t_async_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule